// File: doc/BRIEF.md
# Calendar Update and Alarm Engine

This block keeps the time of day and the date of a real-time clock. Each one-second trigger moves a binary time held inside the block forward by one second. The carries run from seconds through minutes and hours to the day of the week, the day of the month, the month and a two-digit year. The registers that software reads are not changed at that moment. A busy flag rises first. The new time is copied into the registers only after a fixed number of ticks of the 32 kHz clock. At that same point the three-field alarm is compared and the interrupt flag pulses are produced.

The visible registers can use BCD or plain binary, and 12-hour or 24-hour form. Control inputs choose these encodings while the block runs. A host write to a time register is stored at once. While the hold input is low, the write also reloads the internal counters. When the hold input is high, updates still run inside the block but the registers are left alone until the hold is released. Releasing the hold reloads the counters from the registers. A divider-mode field lets the clock run only for one specific code.

Top module: `cal_tick_engine`

## Requirements
- R1: After reset the registers read seconds 0, minutes 0, hours 0, weekday 0, day 1, month 1, year 0, and busy and both flag pulses are low.
- R2: A trigger starts an update only when `osc_sel` equals 3'b010. With any other code the time does not advance, busy stays low and no flag pulses. The next trigger is the next chance to update.
- R3: When an update starts, the internal time advances by one second, and `busy` is high from the next cycle if `hold_set` is low. The registers keep their old values until the window ends.
- R4: On the 8th `tick32k` pulse after the start, the registers take the new time unless `hold_set` is high, and `busy` falls in the same cycle.
- R5: `bin_mode` = 1 selects plain binary bytes and `bin_mode` = 0 selects packed BCD (tens in bits 7:4, units in bits 3:0). The same encoding applies when host writes are decoded and when the time is copied out.
- R6: With `mode24` = 1 the hours byte holds 0 to 23. With `mode24` = 0 it holds the hour modulo 12, and bit 7 set means PM (noon reads 0 with bit 7 set).
- R7: Seconds wrap at 60 and minutes wrap at 60. Hours wrap at 24 and then advance the weekday (0 to 6, modulo 7) and the day of the month. Months 1 to 12 have 31, 28 (29 when the year is a multiple of 4), 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 days. After month 12 the month returns to 1 and the year steps, with 99 going to 0.
- R8: When `alarm_en` is high, `alarm_flag_set` pulses for one cycle at the end of an update if each of the seconds, minutes and hours alarm bytes either equals the new time or has bits 7:6 both set (a wildcard). The alarm bytes use the encoding selected by R5, and the hours alarm holds the hour as 0 to 23.
- R9: When `upd_en` is high, `upd_flag_set` pulses for one cycle at the end of every update. When `upd_en` is low it stays low.
- R10: A host write stores `host_data` into the register picked by `host_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year), visible from the next cycle. With `hold_set` low the internal counters are reloaded from the registers in the same cycle, so the next update counts on from the written value.
- R11: While `hold_set` is high, host writes change only the registers and `busy` is held low. When `hold_set` falls, the counters are reloaded from the registers.
- R12: A trigger that arrives while an update window is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse | input | 1 | One-cycle pulse once per second |
| tick32k | input | 1 | One-cycle pulse per 32 kHz period |
| osc_sel | input | OSC_W | Divider-mode code; only 3'b010 runs the clock |
| hold_set | input | 1 | Freezes the registers against updates |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| mode24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| alarm_en | input | 1 | Alarm flag enable |
| upd_en | input | 1 | Update-ended flag enable |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | SW | Register picked for the write |
| host_data | input | 8 | Write data |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hour | input | 8 | Hours alarm byte |
| reg_sec | output | 8 | Seconds register |
| reg_min | output | 8 | Minutes register |
| reg_hour | output | 8 | Hours register |
| reg_wday | output | 8 | Weekday register |
| reg_mday | output | 8 | Day-of-month register |
| reg_mon | output | 8 | Month register |
| reg_year | output | 8 | Year register |
| busy | output | 1 | Update in progress |
| alarm_flag_set | output | 1 | One-cycle alarm flag pulse |
| upd_flag_set | output | 1 | One-cycle update-ended flag pulse |

## Verification
The internal time is never visible directly. A wrong carry, month length or reload only shows up one update later, when the copy writes the registers on the 8th tick. A wrong tick count shows as registers that change early or late, together with a misplaced fall of `busy`. An error in the window state shows as a second trigger that restarts the count. The bench therefore reads all seven registers right after each window closes, and checks that they are still unchanged one tick before the window closes. The alarm compare is checked with an exact match, with wildcards and with a single mismatching field.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DW     = 8;
  localparam int NFIELD = 7;

  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_WDAY = 3;
  localparam int I_MDAY = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;

  typedef logic [DW-1:0] byte_t;
  typedef logic [NFIELD-1:0][DW-1:0] img_t;

  // year, month, day, weekday, hour, minute, second
  localparam img_t RST_IMG = {8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0};

  function automatic byte_t enc_num(input byte_t v, input logic bin);
    if (bin) return v;
    return byte_t'(((v / 8'd10) << 4) | (v % 8'd10));
  endfunction

  function automatic byte_t dec_num(input byte_t r, input logic bin);
    if (bin) return r;
    return byte_t'({4'd0, r[7:4]} * 8'd10 + {4'd0, r[3:0]});
  endfunction

  function automatic byte_t enc_hour(input byte_t h, input logic bin, input logic m24);
    logic  pm;
    byte_t h12;
    pm  = (h >= 8'd12);
    h12 = pm ? h - 8'd12 : h;
    if (m24) return enc_num(h, bin);
    return enc_num(h12, bin) | {pm, 7'd0};
  endfunction

  function automatic byte_t dec_hour(input byte_t r, input logic bin, input logic m24);
    byte_t h;
    h = dec_num({1'b0, r[6:0]}, bin);
    if (!m24 && r[7]) h = h + 8'd12;
    return h;
  endfunction

  function automatic byte_t days_in_month(input byte_t mon, input byte_t year);
    case (mon)
      8'd2:                    return ((year % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

  function automatic img_t next_second(input img_t t);
    img_t n;
    n = t;
    n[I_SEC] = t[I_SEC] + 8'd1;
    if (n[I_SEC] >= 8'd60) begin
      n[I_SEC] = '0;
      n[I_MIN] = t[I_MIN] + 8'd1;
      if (n[I_MIN] >= 8'd60) begin
        n[I_MIN]  = '0;
        n[I_HOUR] = t[I_HOUR] + 8'd1;
        if (n[I_HOUR] >= 8'd24) begin
          n[I_HOUR] = '0;
          n[I_WDAY] = (t[I_WDAY] >= 8'd6) ? '0 : t[I_WDAY] + 8'd1;
          n[I_MDAY] = t[I_MDAY] + 8'd1;
          if (n[I_MDAY] > days_in_month(t[I_MON], t[I_YEAR])) begin
            n[I_MDAY] = 8'd1;
            n[I_MON]  = t[I_MON] + 8'd1;
            if (n[I_MON] > 8'd12) begin
              n[I_MON]  = 8'd1;
              n[I_YEAR] = (t[I_YEAR] >= 8'd99) ? '0 : t[I_YEAR] + 8'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/cal_window.sv
module cal_window
  import cal_pkg::*;
#(
  parameter int                 UPD_TICKS = 8,
  parameter int                 OSC_W     = 3,
  parameter logic [OSC_W-1:0]   OSC_RUN   = 3'b010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             tick,
  input  logic [OSC_W-1:0] osc_sel,
  input  logic             hold_set,
  output logic             start,
  output logic             fire,
  output logic             busy
);
  localparam int CW = $clog2(UPD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(UPD_TICKS - 1);

  typedef enum logic {W_IDLE, W_WAIT} wstate_e;

  wstate_e       st_q;
  logic [CW-1:0] cnt_q;

  assign start = trig && (osc_sel == OSC_RUN) && (st_q == W_IDLE);
  assign fire  = (st_q == W_WAIT) && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      if (start) begin
        st_q  <= W_WAIT;
        cnt_q <= '0;
        busy  <= !hold_set;
      end else if (st_q == W_WAIT && tick) begin
        if (fire) begin
          st_q <= W_IDLE;
          busy <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (hold_set) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic load,
  input  img_t load_val,
  output img_t now
);
  always_ff @(posedge clk) begin
    if (rst)       now <= RST_IMG;
    else if (load) now <= load_val;
    else if (adv)  now <= next_second(now);
  end
endmodule

// File: rtl/cal_regs.sv
module cal_regs
  import cal_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  img_t          now,
  input  logic          fire,
  input  logic          hold_set,
  input  logic          bin,
  input  logic          m24,
  input  logic          host_wr,
  input  logic [SW-1:0] host_sel,
  input  byte_t         host_data,
  output img_t          regs,
  output logic          load,
  output img_t          load_val
);
  img_t enc_img;
  img_t wr_img;
  logic set_q;

  always_comb begin
    for (int i = 0; i < NFIELD; i++) enc_img[i] = enc_num(now[i], bin);
    enc_img[I_HOUR] = enc_hour(now[I_HOUR], bin, m24);
  end

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_fld
    logic  hit;
    byte_t q;
    assign hit = host_wr && (host_sel == SW'(gi));
    always_ff @(posedge clk) begin
      if (rst)                   q <= RST_IMG[gi];
      else if (hit)              q <= host_data;
      else if (fire && !hold_set) q <= enc_img[gi];
    end
    assign regs[gi]   = q;
    assign wr_img[gi] = hit ? host_data : q;
  end

  always_comb begin
    for (int i = 0; i < NFIELD; i++) load_val[i] = dec_num(wr_img[i], bin);
    load_val[I_HOUR] = dec_hour(wr_img[I_HOUR], bin, m24);
  end

  always_ff @(posedge clk) begin
    if (rst) set_q <= 1'b0;
    else     set_q <= hold_set;
  end

  assign load = !hold_set &&
                ((host_wr && host_sel < SW'(NFIELD)) || set_q);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  logic  alarm_en,
  input  logic  upd_en,
  input  logic  bin,
  input  img_t  now,
  input  byte_t alm_sec,
  input  byte_t alm_min,
  input  byte_t alm_hour,
  output logic  alarm_set,
  output logic  upd_set
);
  localparam int NALM = 3;

  logic [NALM-1:0][DW-1:0] alm;
  logic [NALM-1:0][DW-1:0] cur;
  logic [NALM-1:0]         ok;

  assign alm = {alm_hour, alm_min, alm_sec};
  assign cur = {now[I_HOUR], now[I_MIN], now[I_SEC]};

  for (genvar g = 0; g < NALM; g++) begin : g_cmp
    assign ok[g] = (alm[g][DW-1 -: 2] == 2'b11) || (dec_num(alm[g], bin) == cur[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_set <= 1'b0;
      upd_set   <= 1'b0;
    end else begin
      alarm_set <= fire && alarm_en && (&ok);
      upd_set   <= fire && upd_en;
    end
  end
endmodule

// File: rtl/cal_tick_engine.sv
module cal_tick_engine
  import cal_pkg::*;
#(
  parameter int               UPD_TICKS = 8,
  parameter int               OSC_W     = 3,
  parameter logic [OSC_W-1:0] OSC_RUN   = 3'b010,
  parameter int               SW        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_pulse,
  input  logic             tick32k,
  input  logic [OSC_W-1:0] osc_sel,
  input  logic             hold_set,
  input  logic             bin_mode,
  input  logic             mode24,
  input  logic             alarm_en,
  input  logic             upd_en,
  input  logic             host_wr,
  input  logic [SW-1:0]    host_sel,
  input  logic [7:0]       host_data,
  input  logic [7:0]       alarm_sec,
  input  logic [7:0]       alarm_min,
  input  logic [7:0]       alarm_hour,
  output logic [7:0]       reg_sec,
  output logic [7:0]       reg_min,
  output logic [7:0]       reg_hour,
  output logic [7:0]       reg_wday,
  output logic [7:0]       reg_mday,
  output logic [7:0]       reg_mon,
  output logic [7:0]       reg_year,
  output logic             busy,
  output logic             alarm_flag_set,
  output logic             upd_flag_set
);
  logic start, fire, load;
  img_t now, regs, load_val;

  cal_window #(.UPD_TICKS(UPD_TICKS), .OSC_W(OSC_W), .OSC_RUN(OSC_RUN)) win_i (
    .clk(clk), .rst(rst), .trig(sec_pulse), .tick(tick32k), .osc_sel(osc_sel),
    .hold_set(hold_set), .start(start), .fire(fire), .busy(busy)
  );

  cal_counter cnt_i (
    .clk(clk), .rst(rst), .adv(start), .load(load), .load_val(load_val), .now(now)
  );

  cal_regs #(.SW(SW)) regs_i (
    .clk(clk), .rst(rst), .now(now), .fire(fire), .hold_set(hold_set),
    .bin(bin_mode), .m24(mode24), .host_wr(host_wr), .host_sel(host_sel),
    .host_data(host_data), .regs(regs), .load(load), .load_val(load_val)
  );

  cal_alarm alm_i (
    .clk(clk), .rst(rst), .fire(fire), .alarm_en(alarm_en), .upd_en(upd_en),
    .bin(bin_mode), .now(now), .alm_sec(alarm_sec), .alm_min(alarm_min),
    .alm_hour(alarm_hour), .alarm_set(alarm_flag_set), .upd_set(upd_flag_set)
  );

  assign reg_sec  = regs[I_SEC];
  assign reg_min  = regs[I_MIN];
  assign reg_hour = regs[I_HOUR];
  assign reg_wday = regs[I_WDAY];
  assign reg_mday = regs[I_MDAY];
  assign reg_mon  = regs[I_MON];
  assign reg_year = regs[I_YEAR];
endmodule

// File: rtl/cal_tick_engine_chk.sv
module cal_tick_engine_chk #(
  parameter int               OSC_W   = 3,
  parameter logic [OSC_W-1:0] OSC_RUN = 3'b010
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_pulse,
  input logic [OSC_W-1:0] osc_sel,
  input logic             hold_set,
  input logic             host_wr,
  input logic             alarm_en,
  input logic             upd_en,
  input logic             busy,
  input logic             alarm_flag_set,
  input logic             upd_flag_set,
  input logic [7:0]       reg_sec
);
  // R11
  set_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    hold_set |=> !busy);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(sec_pulse && osc_sel == OSC_RUN)) |=> !busy);

  // R4
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !host_wr) |=> ($stable(reg_sec) || $fell(busy)));

  // R8
  alarm_en_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_flag_set |-> $past(alarm_en));

  // R8
  alarm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_flag_set |=> !alarm_flag_set);

  // R9
  upd_en_chk: assert property (@(posedge clk) disable iff (rst)
    upd_flag_set |-> $past(upd_en));

  // R9
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    upd_flag_set |=> !upd_flag_set);
endmodule

bind cal_tick_engine cal_tick_engine_chk #(.OSC_W(OSC_W), .OSC_RUN(OSC_RUN)) chk_i (
  .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .osc_sel(osc_sel), .hold_set(hold_set),
  .host_wr(host_wr), .alarm_en(alarm_en), .upd_en(upd_en), .busy(busy),
  .alarm_flag_set(alarm_flag_set), .upd_flag_set(upd_flag_set), .reg_sec(reg_sec)
);

// File: tb/cal_tick_engine_tb_top.sv
`timescale 1ns/1ps
module cal_tick_engine_tb_top;
  localparam int UPD = 8;
  localparam int NV  = 13;

  typedef struct packed {
    logic        bin;
    logic        m24;
    logic [55:0] st;
    logic [55:0] ex;
  } vec_t;

  // byte order in st/ex: sec, min, hour, wday, mday, mon, year
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 56'h59592306311299, 56'h00000000010100},
    '{1'b0, 1'b1, 56'h56341202150723, 56'h57341202150723},
    '{1'b0, 1'b1, 56'h59592301280223, 56'h00000002010323},
    '{1'b0, 1'b1, 56'h59592301280224, 56'h00000002290224},
    '{1'b0, 1'b1, 56'h59592301290200, 56'h00000002010300},
    '{1'b1, 1'b1, 56'h3B3B17031E0432, 56'h00000004010532},
    '{1'b0, 1'b0, 56'h59591100100530, 56'h00008000100530},
    '{1'b0, 1'b0, 56'h59599100100530, 56'h00000001110530},
    '{1'b1, 1'b0, 56'h3B3B8105090A14, 56'h00008205090A14},
    '{1'b0, 1'b1, 56'h59590904300615, 56'h00001004300615},
    '{1'b0, 1'b1, 56'h59592306310121, 56'h00000000010221},
    '{1'b0, 1'b1, 56'h59592305300621, 56'h00000006010721},
    '{1'b0, 1'b1, 56'h59592303280200, 56'h00000004290200}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_pulse = 1'b0, tick32k = 1'b0;
  logic [2:0] osc_sel = 3'b010;
  logic       hold_set = 1'b0, bin_mode = 1'b0, mode24 = 1'b1;
  logic       alarm_en = 1'b0, upd_en = 1'b1, host_wr = 1'b0;
  logic [2:0] host_sel = '0;
  logic [7:0] host_data = '0, alarm_sec = '0, alarm_min = '0, alarm_hour = '0;
  logic [7:0] reg_sec, reg_min, reg_hour, reg_wday, reg_mday, reg_mon, reg_year;
  logic       busy, alarm_flag_set, upd_flag_set;

  int  total = 0, bad = 0;
  bit  done = 0;
  logic al_seen, up_seen;

  always #2.5 clk = ~clk;

  cal_tick_engine dut_i (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .tick32k(tick32k), .osc_sel(osc_sel),
    .hold_set(hold_set), .bin_mode(bin_mode), .mode24(mode24), .alarm_en(alarm_en),
    .upd_en(upd_en), .host_wr(host_wr), .host_sel(host_sel), .host_data(host_data),
    .alarm_sec(alarm_sec), .alarm_min(alarm_min), .alarm_hour(alarm_hour),
    .reg_sec(reg_sec), .reg_min(reg_min), .reg_hour(reg_hour), .reg_wday(reg_wday),
    .reg_mday(reg_mday), .reg_mon(reg_mon), .reg_year(reg_year), .busy(busy),
    .alarm_flag_set(alarm_flag_set), .upd_flag_set(upd_flag_set)
  );

  function automatic logic [55:0] cur();
    return {reg_sec, reg_min, reg_hour, reg_wday, reg_mday, reg_mon, reg_year};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_sel = sel; host_data = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(3'(i), t[55-8*i -: 8]);
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_pulse = 1'b1;
    @(negedge clk); sec_pulse = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick32k = 1'b1;
    @(negedge clk); tick32k = 1'b0;
  endtask

  task automatic run_update(input logic exp_busy, input string tag);
    logic [55:0] pre;
    pre = cur();
    pulse_sec();
    chk(busy == exp_busy, {"R3 busy after start ", tag}, 64'(busy), 64'(exp_busy));
    for (int k = 0; k < UPD - 1; k++) pulse_tick();
    chk(cur() == pre, {"R3 regs unchanged in window ", tag}, 64'(cur()), 64'(pre));
    pulse_tick();
    al_seen = alarm_flag_set;
    up_seen = upd_flag_set;
    chk(busy == 1'b0, {"R4 busy low at refresh ", tag}, 64'(busy), 64'd0);
    @(negedge clk);
    chk(!alarm_flag_set && !upd_flag_set, {"R8 R9 one-cycle pulses ", tag},
        64'({alarm_flag_set, upd_flag_set}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all) act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cur() == 56'h00000000010100, "R1 reset registers", 64'(cur()), 64'h00000000010100);
    chk(!busy && !alarm_flag_set && !upd_flag_set, "R1 reset flags",
        64'({busy, alarm_flag_set, upd_flag_set}), 64'd0);

    // R5 R6 R7 vectors
    for (int v = 0; v < NV; v++) begin
      bin_mode = VEC[v].bin;
      mode24   = VEC[v].m24;
      set_time(VEC[v].st);
      run_update(1'b1, $sformatf("vec %0d", v));
      chk(cur() == VEC[v].ex, $sformatf("R7 vector %0d (R5 R6 encodings)", v), 64'(cur()), 64'(VEC[v].ex));
      chk(up_seen && !al_seen, $sformatf("R9 vector %0d flags", v), 64'({al_seen, up_seen}), 64'd1);
    end

    // R2 gating
    bin_mode = 1'b0; mode24 = 1'b1;
    set_time(56'h29201001050325);
    osc_sel = 3'b110;
    pulse_sec();
    chk(!busy, "R2 no busy when gated", 64'(busy), 64'd0);
    for (int k = 0; k < UPD; k++) pulse_tick();
    chk(cur() == 56'h29201001050325, "R2 time held", 64'(cur()), 64'h29201001050325);
    chk(!alarm_flag_set && !upd_flag_set, "R2 no flags", 64'({alarm_flag_set, upd_flag_set}), 64'd0);
    osc_sel = 3'b010;
    run_update(1'b1, "gate release");
    chk(reg_sec == 8'h30, "R2 single step after release", 64'(reg_sec), 64'h30);

    // R8 alarm
    alarm_sec = 8'h31; alarm_min = 8'h20; alarm_hour = 8'h10; alarm_en = 1'b1;
    run_update(1'b1, "alarm exact");
    chk(al_seen == 1'b1, "R8 exact match", 64'(al_seen), 64'd1);
    alarm_sec = 8'hC0;
    run_update(1'b1, "alarm wild");
    chk(al_seen == 1'b1, "R8 wildcard seconds", 64'(al_seen), 64'd1);
    alarm_min = 8'h21;
    run_update(1'b1, "alarm miss");
    chk(al_seen == 1'b0, "R8 minute mismatch", 64'(al_seen), 64'd0);
    alarm_min = 8'hC0; alarm_hour = 8'hC0; alarm_en = 1'b0;
    run_update(1'b1, "alarm off");
    chk(al_seen == 1'b0, "R8 disabled", 64'(al_seen), 64'd0);
    alarm_en = 1'b1; upd_en = 1'b0;
    run_update(1'b1, "upd off");
    chk(al_seen == 1'b1 && up_seen == 1'b0, "R9 update flag disabled", 64'({al_seen, up_seen}), 64'h2);
    chk(reg_sec == 8'h35, "R8 time after alarm runs", 64'(reg_sec), 64'h35);
    alarm_en = 1'b0; upd_en = 1'b1;

    // R12 trigger inside window
    pulse_sec();
    for (int k = 0; k < 3; k++) pulse_tick();
    pulse_sec();
    for (int k = 0; k < UPD - 3; k++) pulse_tick();
    chk(reg_sec == 8'h36 && !busy, "R12 second trigger ignored", 64'({busy, reg_sec}), 64'h36);

    // R10 host write reloads counters
    wr(3'd1, 8'h45);
    chk(reg_min == 8'h45, "R10 write visible", 64'(reg_min), 64'h45);
    run_update(1'b1, "after write");
    chk(reg_sec == 8'h37 && reg_min == 8'h45, "R10 counts from written value",
        64'({reg_min, reg_sec}), 64'h4537);

    // R11 hold behaviour
    set_time(56'h00150803120921);
    hold_set = 1'b1;
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h16);
    chk(reg_sec == 8'h05 && reg_min == 8'h16, "R11 writes visible under hold",
        64'({reg_min, reg_sec}), 64'h1605);
    run_update(1'b0, "under hold");
    chk(cur() == 56'h05160803120921, "R11 no copy under hold", 64'(cur()), 64'h05160803120921);
    @(negedge clk); hold_set = 1'b0;
    @(negedge clk);
    run_update(1'b1, "after hold release");
    chk(cur() == 56'h06160803120921, "R11 reload on hold release", 64'(cur()), 64'h06160803120921);
    pulse_sec();
    chk(busy == 1'b1, "R3 busy before hold", 64'(busy), 64'd1);
    @(negedge clk); hold_set = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11 hold clears busy", 64'(busy), 64'd0);
    for (int k = 0; k < UPD; k++) pulse_tick();
    chk(reg_sec == 8'h06, "R11 copy suppressed", 64'(reg_sec), 64'h06);
    @(negedge clk); hold_set = 1'b0;
    @(negedge clk);
    run_update(1'b1, "final");
    chk(reg_sec == 8'h07, "R11 continue from registers", 64'(reg_sec), 64'h07);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule